// File: doc/BRIEF.md
# Lens-Driver Configuration Write Target on a Two-Wire Serial Bus

This block is a receive-only target on a standard two-wire serial bus (I2C, up to 400 kHz SCL). It loads the configuration of a camera lens driver: a 10-bit focus current code and an 8-bit H-bridge control byte. A fast system clock samples both bus lines. The block detects start and stop conditions, matches its fixed 7-bit address and pulls the data line low to acknowledge each byte it accepts.

After the address byte, the next byte sets a register pointer. Each later data byte goes to the register the pointer selects. Pointer 00h holds the focus code in two bytes, high byte first. The block keeps the high byte aside and changes the focus code only when the low byte arrives. After the low byte the pointer moves to 01h. A write at 01h moves it to 02h, and from 02h upward the pointer no longer moves. Bytes sent there are acknowledged and then dropped.

Top module: `lens_cfg_i2c_target`

## Requirements
- R1: After reset `focusCode` is 0, `bridgeCtrl` is 0 and `sdaPullLow` is 0.
- R2: A byte sent after a start that equals 0x66 (address 0110011 in bits 7..1, MSB first, bit 0 = 0 for write) is acknowledged: `sdaPullLow` is 1 while SCL is high for the 9th pulse.
- R3: If the first byte after a start is any other value, including 0x67 (a read), that byte and every byte up to the next start are left unacknowledged and change no output.
- R4: In an addressed transfer, the byte after the address loads the register pointer and is acknowledged. Each byte after that is acknowledged and written at the pointer.
- R5: At pointer 00h, the first data byte's bits 1..0 become focus bits 9..8, and its bits 7..2 are ignored. The second data byte becomes focus bits 7..0. `focusCode` changes only when the second byte is accepted, and the pointer then becomes 01h. Loading the pointer again restarts the sequence with the high byte.
- R6: A data byte written at pointer 01h is copied to `bridgeCtrl`, and the pointer becomes 02h.
- R7: At a pointer of 02h or higher, data bytes are acknowledged but change no output, and the pointer keeps its value.
- R8: A byte cut short by a stop before its acknowledge clock ends writes nothing.
- R9: A repeated start, with no stop before it, makes the next byte an address byte again.
- R10: Bytes clocked after a stop and before the next start are not acknowledged and change nothing.
- R11: `sdaPullLow` is 0 while SCL is high for data bits. It rises only after the 8th SCL falling edge and falls again after the 9th SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaPullLow | output | 1 | 1 = drive the data line low (acknowledge), 0 = release it |
| focusCode | output | FOCUS_W (10) | Focus current code |
| bridgeCtrl | output | 8 | H-bridge control byte |

## Verification
The bench uses the default parameters: address 0110011, a 10-bit focus code and two synchronizer stages. Its bus model holds SCL for 20 system clocks per half period. With these settings, the acknowledge appears well inside the 9th SCL high phase, and the release after the 9th falling edge can be seen within a few clocks. The 10-bit focus width leaves six unused bits in the high byte, so the bench can show that they are dropped. Because the pointer stops at 02h and stays above it, long bursts and out-of-range pointers can be checked at the ports through the unchanged outputs.

// File: rtl/lens_cfg_pkg.sv
package lens_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_IGNORE
  } rxState_e;

  typedef struct packed {
    logic shiftEn;
    logic ptrLoad;
    logic dataWr;
  } rxStrobe_t;
endpackage

// File: rtl/lens_cfg_sync.sv
module lens_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
endmodule

// File: rtl/lens_cfg_ctrl.sv
module lens_cfg_ctrl
  import lens_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      addrHit,
  output rxStrobe_t stb,
  output logic      sdaPullLow
);
  rxState_e   state;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;   // 0 address, 1 pointer, 2 data
  logic       ackEnd;

  assign ackEnd = (state == ST_ACK) && sclFall && !startDet && !stopDet;

  always_comb begin
    stb.shiftEn = (state == ST_RECV) && sclRise && (bitCnt < 4'd8);
    stb.ptrLoad = ackEnd && (byteIdx == 2'd1);
    stb.dataWr  = ackEnd && (byteIdx == 2'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      byteIdx    <= '0;
      sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state      <= ST_RECV;
      bitCnt     <= '0;
      byteIdx    <= '0;
      sdaPullLow <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (stb.shiftEn) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (byteIdx == 2'd0 && !addrHit) begin
              state <= ST_IGNORE;
            end else begin
              state      <= ST_ACK;
              sdaPullLow <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state      <= ST_RECV;
            sdaPullLow <= 1'b0;
            bitCnt     <= '0;
            if (byteIdx != 2'd2) byteIdx <= byteIdx + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) || $fell(sdaPullLow)) |-> !sclS); // R11
  AST_ACK_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> (bitCnt == 4'd8)); // R2
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet) |=> (state == ST_RECV && byteIdx == 2'd0 && bitCnt == 4'd0)); // R9
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_IGNORE && !$past(startDet)) |-> !sdaPullLow); // R3
endmodule

// File: rtl/lens_cfg_dp.sv
module lens_cfg_dp
  import lens_cfg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011,
  parameter int         FOCUS_W     = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaS,
  input  rxStrobe_t          stb,
  output logic               addrHit,
  output logic [FOCUS_W-1:0] focusCode,
  output logic [BYTE_W-1:0]  bridgeCtrl
);
  localparam int HI_W = FOCUS_W - BYTE_W;
  localparam logic [BYTE_W-1:0] PTR_FOCUS  = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_BRIDGE = 8'h01;
  localparam logic [BYTE_W-1:0] PTR_LAST   = 8'h02;

  logic [BYTE_W-1:0] byteSr;
  logic [BYTE_W-1:0] regPtr;
  logic              hiPhase;
  logic [HI_W-1:0]   stagedHi;

  assign addrHit = (byteSr == {TARGET_ADDR, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteSr     <= '0;
      regPtr     <= PTR_FOCUS;
      hiPhase    <= 1'b1;
      stagedHi   <= '0;
      focusCode  <= '0;
      bridgeCtrl <= '0;
    end else begin
      if (stb.shiftEn) byteSr <= {byteSr[BYTE_W-2:0], sdaS};
      if (stb.ptrLoad) begin
        regPtr  <= byteSr;
        hiPhase <= 1'b1;
      end else if (stb.dataWr) begin
        if (regPtr == PTR_FOCUS) begin
          if (hiPhase) begin
            stagedHi <= byteSr[HI_W-1:0];
            hiPhase  <= 1'b0;
          end else begin
            focusCode <= {stagedHi, byteSr};
            regPtr    <= PTR_BRIDGE;
            hiPhase   <= 1'b1;
          end
        end else if (regPtr == PTR_BRIDGE) begin
          bridgeCtrl <= byteSr;
          regPtr     <= PTR_LAST;
        end
      end
    end
  end

  AST_PTR_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (regPtr >= PTR_LAST && !stb.ptrLoad) |=> (regPtr == $past(regPtr))); // R7
  AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.dataWr |=> ($stable(focusCode) && $stable(bridgeCtrl))); // R8
  AST_FOCUS_MOVES_PTR: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(focusCode) |-> (regPtr == PTR_BRIDGE)); // R5
endmodule

// File: rtl/lens_cfg_i2c_target.sv
module lens_cfg_i2c_target
  import lens_cfg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011,
  parameter int         FOCUS_W     = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  output logic [FOCUS_W-1:0] focusCode,
  output logic [7:0]         bridgeCtrl
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet, addrHit;
  rxStrobe_t stb;

  lens_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  lens_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .addrHit(addrHit), .stb(stb), .sdaPullLow(sdaPullLow)
  );

  lens_cfg_dp #(.TARGET_ADDR(TARGET_ADDR), .FOCUS_W(FOCUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .stb(stb), .addrHit(addrHit),
    .focusCode(focusCode), .bridgeCtrl(bridgeCtrl)
  );
endmodule

// File: tb/sim_lens_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_lens_cfg_i2c_target;
  localparam int H = 20;  // SCL half period in system clocks
  localparam int Q = 10;
  localparam int NV = 10;
  // {count[74:72], bytes[71:24] left aligned, ackMask[23:18], focus[17:8], bridge[7:0]}
  localparam logic [74:0] VEC [NV] = '{
    {3'd4, 48'h660003A50000, 6'b111100, 10'h3A5, 8'h00}, // R5 focus pair
    {3'd3, 48'h66015C000000, 6'b111000, 10'h3A5, 8'h5C}, // R6 bridge
    {3'd6, 48'h66000123C377, 6'b111111, 10'h123, 8'hC3}, // R4 burst, 77 lands at 02h (R7)
    {3'd4, 48'h660211220000, 6'b111100, 10'h123, 8'hC3}, // R7 pointer 02h
    {3'd4, 48'h67000FFF0000, 6'b000000, 10'h123, 8'hC3}, // R3 read bit
    {3'd3, 48'h6401AA000000, 6'b000000, 10'h123, 8'hC3}, // R3 wrong address
    {3'd3, 48'h660544000000, 6'b111000, 10'h123, 8'hC3}, // R7 pointer 05h
    {3'd3, 48'h660002000000, 6'b111000, 10'h123, 8'hC3}, // R5 high byte only
    {3'd4, 48'h660000100000, 6'b111100, 10'h010, 8'hC3}, // R5 restart with high byte
    {3'd4, 48'h6600FE4B0000, 6'b111100, 10'h24B, 8'hC3}  // R5 upper bits dropped
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic [9:0] focusCode;
  logic [7:0] bridgeCtrl;
  logic sdaBus;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  lens_cfg_i2c_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .focusCode(focusCode), .bridgeCtrl(bridgeCtrl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(H);
      if (i == 0) check({15'd0, sdaPullLow}, 16'd0, "R11 released on 8th bit");
      sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    sendBits(b, 8);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(H / 2);
    check({15'd0, ~sdaBus}, {15'd0, expAck}, req);
    tick(H / 2);
    sclM = 1'b0; tick(10);
    if (expAck) check({15'd0, sdaPullLow}, 16'd0, "R11 released after 9th fall");
  endtask

  initial begin
    tick(5);
    check({15'd0, sdaPullLow}, 16'd0, "R1 sdaPullLow");
    check({6'd0, focusCode}, 16'd0, "R1 focusCode");
    check({8'd0, bridgeCtrl}, 16'd0, "R1 bridgeCtrl");
    rstN = 1'b1;
    tick(5);

    for (int v = 0; v < NV; v++) begin
      busStart();
      for (int k = 0; k < int'(VEC[v][74:72]); k++)
        sendByte(VEC[v][71 - 8*k -: 8], VEC[v][23 - k], "R2 R3 R4 ack");
      busStop();
      check({6'd0, focusCode}, {6'd0, VEC[v][17:8]}, "R4 R5 table focusCode");
      check({8'd0, bridgeCtrl}, {8'd0, VEC[v][7:0]}, "R6 R7 table bridgeCtrl");
    end

    // R8: focus low byte cut short by a stop
    busStart();
    sendByte(8'h66, 1'b1, "R8 ack");
    sendByte(8'h00, 1'b1, "R8 ack");
    sendByte(8'h03, 1'b1, "R8 ack");
    sendBits(8'h77, 5);
    busStop();
    check({6'd0, focusCode}, 16'h024B, "R8 partial focus byte");
    busStart();
    sendByte(8'h66, 1'b1, "R8 ack");
    sendByte(8'h01, 1'b1, "R8 ack");
    sendBits(8'h11, 3);
    busStop();
    check({8'd0, bridgeCtrl}, 16'h00C3, "R8 partial bridge byte");

    // R9: repeated start
    busStart();
    sendByte(8'h66, 1'b1, "R9 ack");
    busStart();
    sendByte(8'h66, 1'b1, "R9 address after repeated start");
    sendByte(8'h01, 1'b1, "R9 ack");
    sendByte(8'h3C, 1'b1, "R9 ack");
    busStop();
    check({8'd0, bridgeCtrl}, 16'h003C, "R9 bridge after repeated start");

    // R10: bytes without a start
    sclM = 1'b0; tick(Q);
    sendByte(8'h66, 1'b0, "R10 no ack without start");
    sendByte(8'h01, 1'b0, "R10 no ack without start");
    sendByte(8'h99, 1'b0, "R10 no ack without start");
    busStop();
    check({8'd0, bridgeCtrl}, 16'h003C, "R10 bridge unchanged");
    check({6'd0, focusCode}, 16'h024B, "R10 focus unchanged");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule